// File: doc/BRIEF.md
# Request-Acknowledge Random Generator Register Front End

This block is the register face of a deterministic random generator. Software starts work by setting a request bit in a control word. Five kinds of work exist: instantiate, reseed, self-test, a software-driven deterministic draw and a software-driven true-random draw. When a piece of work finishes, the block sets a matching acknowledge bit in a state word. That bit stays set until software writes a 1 to it. A deterministic draw leaves eight fresh 32-bit words in a result window that software reads back.

The control word takes per-bit masked writes: the upper half of a write selects which lower-half bits actually change. Software can therefore raise or drop one request without a read-modify-write. A write of all zeros with a full mask drops every request, which stops any work in progress. The generator behind the registers is a stand-in, a 32-bit linear feedback shift register, in place of a real DRBG algorithm.

The register port is a plain single-cycle bus. It has no valid/ready pairing and never applies back-pressure. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`, reflects the register contents as of the last edge, and software may read any address in any cycle.

Top module: `drng_handshake_regs`

## Requirements
- R1: After reset, the control word, the state word and all eight result words read 0, and the generator state equals the `SEED` parameter.
- R2: Address map. Control word at 0x10, with bit 0 instantiate, bit 1 reseed, bit 2 self-test, bit 3 software deterministic draw and bit 4 software true-random draw. State word at 0x14, with acknowledge bits in the same positions. Result word k at 0x70+4k, for k = 0..7. Unused bits and unmapped addresses read 0. Writes to the result window or to unmapped addresses change nothing.
- R3: A write to 0x10 changes request bit i (i = 0..4) to `bus_wdata[i]` only when mask bit `bus_wdata[16+i]` is 1. Request bits whose mask bit is 0 keep their value.
- R4: An acknowledge bit is sticky. Writing 1 to bit i of 0x14 clears it, and writing 0 leaves it unchanged. When a completion and a clearing write fall on the same edge, the bit ends up set.
- R5: While the engine is idle, a pending request starts on the edge after it becomes visible. The work completes `OP_CYCLES` edges later, so the acknowledge bit reads 1 from `OP_CYCLES`+1 edges after the request write. On that completion edge the request bit drops to 0, even if software writes it to 1 on the same edge.
- R6: When several requests are pending, they are served one at a time, lowest bit first. Each work item takes `OP_CYCLES`+1 edges including its start, so request bit i of a set written together with bits 0..4 acknowledges at (i+1)*(`OP_CYCLES`+1) edges after the write.
- R7: If the request bit of the work in progress is dropped (for example by writing 0xFFFF0000 to 0x10), that work is abandoned: the engine goes idle on the next edge, and no acknowledge and no result update follow.
- R8: The result words change only on the completion edge of a software deterministic draw. At that edge, word k takes step^(k+1)(G), where G is the generator state just before the edge.
- R9: The generator uses step(s) = (s >> 1) XOR (s[0] ? 0x80200003 : 0), with the tap constant given by the `TAPS` parameter. It advances one step on every edge at which the engine is busy. On an instantiate completion it instead loads `SEED`. On a reseed completion it instead loads step(s) XOR `MIX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe, one write per edge |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data; for 0x10 the upper half is the bit mask |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |

## Verification
The bound checker covers the cycle-local rules on every cycle:
- an acknowledge bit never drops except under a clearing write;
- a newly set acknowledge always comes with its request cleared;
- a masked control write leaves the unmasked request bits alone;
- the engine always starts on the lowest pending request;
- an abandoned item idles the engine on the next edge;
- the result words change only after a deterministic-draw completion.

The exact completion latency, the spacing of a five-deep request burst, the result values from a known seed, and the outcome of same-edge collisions between software writes and completions can only be shown by the bench scenarios against its reference model.

// File: rtl/drng_hs_pkg.sv
package drng_hs_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int N_OPS  = 5;
  localparam int OP_W   = $clog2(N_OPS);

  // work kinds; the bit position of each is its request/acknowledge bit
  localparam logic [OP_W-1:0] OP_INST    = OP_W'(0);
  localparam logic [OP_W-1:0] OP_RESEED  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_SELFTST = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SWDET   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_SWTRUE  = OP_W'(4);

  localparam logic [ADDR_W-1:0] ADDR_REQ   = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_ACK   = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_WIN0  = 8'h70;

  localparam int MASK_LSB = 16;

  function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s,
                                                   input logic [DATA_W-1:0] taps);
    return (s >> 1) ^ (s[0] ? taps : '0);
  endfunction
endpackage

// File: rtl/drng_hs_arb.sv
module drng_hs_arb
  import drng_hs_pkg::*;
(
  input  logic [N_OPS-1:0] req_i,
  output logic             vld_o,
  output logic [OP_W-1:0]  idx_o
);
  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = OP_W'(i);
    end
  end
endmodule

// File: rtl/drng_hs_engine.sv
module drng_hs_engine
  import drng_hs_pkg::*;
#(
  parameter int OP_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OPS-1:0] req_i,
  output logic             busy_o,
  output logic [OP_W-1:0]  op_o,
  output logic             done_o
);
  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OP_CYCLES - 1);

  logic             busy_q;
  logic [OP_W-1:0]  op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pick_vld;
  logic [OP_W-1:0]  pick_idx;
  logic             still_req;

  drng_hs_arb u_arb (
    .req_i (req_i),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  assign still_req = req_i[op_q];
  assign done_o    = busy_q && still_req && (cnt_q == CNT_LAST);
  assign busy_o    = busy_q;
  assign op_o      = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (pick_vld) begin
        busy_q <= 1'b1;
        op_q   <= pick_idx;
        cnt_q  <= '0;
      end
    end else if (!still_req || done_o) begin
      // abandoned or finished: back to idle
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/drng_hs_gen.sv
module drng_hs_gen
  import drng_hs_pkg::*;
#(
  parameter int                N_WORDS = 8,
  parameter logic [DATA_W-1:0] SEED    = 32'hACE1_0001,
  parameter logic [DATA_W-1:0] TAPS    = 32'h8020_0003,
  parameter logic [DATA_W-1:0] MIX     = 32'h5A5A_C3C3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy_i,
  input  logic                      done_i,
  input  logic [OP_W-1:0]           op_i,
  output logic [N_WORDS*DATA_W-1:0] words_o
);
  logic [DATA_W-1:0] state_q;
  logic [DATA_W-1:0] chain [N_WORDS+1];

  assign chain[0] = state_q;

  // unrolled look-ahead: word k is the state k+1 steps ahead
  for (genvar k = 0; k < N_WORDS; k++) begin : g_ahead
    assign chain[k+1] = lfsr_step(chain[k], TAPS);
    assign words_o[k*DATA_W +: DATA_W] = chain[k+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (busy_i) begin
      if (done_i && op_i == OP_INST)        state_q <= SEED;
      else if (done_i && op_i == OP_RESEED) state_q <= chain[1] ^ MIX;
      else                                   state_q <= chain[1];
    end
  end
endmodule

// File: rtl/drng_hs_regs.sv
module drng_hs_regs
  import drng_hs_pkg::*;
#(
  parameter int N_WORDS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      done_i,
  input  logic [OP_W-1:0]           op_i,
  input  logic [N_WORDS*DATA_W-1:0] gen_words_i,
  output logic [N_OPS-1:0]          req_o,
  output logic [N_OPS-1:0]          ack_o,
  output logic [N_WORDS*DATA_W-1:0] data_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_WIN0 + ADDR_W'(4 * N_WORDS);

  logic [N_OPS-1:0]  req_q, ack_q, req_d, ack_d;
  logic [N_OPS-1:0]  wmask, wclr, done_vec;
  logic [DATA_W-1:0] data_q [N_WORDS];
  logic [ADDR_W-1:0] win_off;
  logic              req_wr, ack_wr, take_words;
  logic              unused_wbits;

  assign req_wr     = bus_we && (bus_addr == ADDR_REQ);
  assign ack_wr     = bus_we && (bus_addr == ADDR_ACK);
  assign wmask      = req_wr ? bus_wdata[MASK_LSB +: N_OPS] : '0;
  assign wclr       = ack_wr ? bus_wdata[N_OPS-1:0] : '0;
  assign take_words = done_i && (op_i == OP_SWDET);
  assign unused_wbits = ^{bus_wdata[DATA_W-1:MASK_LSB+N_OPS], bus_wdata[MASK_LSB-1:N_OPS]};

  always_comb begin
    done_vec = '0;
    if (done_i) done_vec[op_i] = 1'b1;
    // hardware completion overrides a same-edge software write
    req_d = ((req_q & ~wmask) | (bus_wdata[N_OPS-1:0] & wmask)) & ~done_vec;
    ack_d = (ack_q & ~wclr) | done_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      ack_q <= '0;
    end else begin
      req_q <= req_d;
      ack_q <= ack_d;
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)          data_q[k] <= '0;
      else if (take_words) data_q[k] <= gen_words_i[k*DATA_W +: DATA_W];
    end
    assign data_o[k*DATA_W +: DATA_W] = data_q[k];
  end

  assign win_off = bus_addr - ADDR_WIN0;

  always_comb begin
    rdata_o = '0;
    if (bus_addr == ADDR_REQ)
      rdata_o[N_OPS-1:0] = req_q;
    else if (bus_addr == ADDR_ACK)
      rdata_o[N_OPS-1:0] = ack_q;
    else if (bus_addr >= ADDR_WIN0 && bus_addr < WIN_END && bus_addr[1:0] == 2'b00)
      rdata_o = data_q[win_off[IDX_W+1:2]];
  end

  assign req_o = req_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/drng_handshake_regs.sv
module drng_handshake_regs
  import drng_hs_pkg::*;
#(
  parameter int          OP_CYCLES = 64,
  parameter int          N_WORDS   = 8,
  parameter logic [31:0] SEED      = 32'hACE1_0001,
  parameter logic [31:0] TAPS      = 32'h8020_0003,
  parameter logic [31:0] MIX       = 32'h5A5A_C3C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic [N_OPS-1:0]          req_vec, ack_vec;
  logic                      eng_busy, eng_done;
  logic [OP_W-1:0]           eng_op;
  logic [N_WORDS*DATA_W-1:0] gen_words, data_flat;

  drng_hs_regs #(.N_WORDS(N_WORDS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .done_i      (eng_done),
    .op_i        (eng_op),
    .gen_words_i (gen_words),
    .req_o       (req_vec),
    .ack_o       (ack_vec),
    .data_o      (data_flat),
    .rdata_o     (bus_rdata)
  );

  drng_hs_engine #(.OP_CYCLES(OP_CYCLES)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_vec),
    .busy_o (eng_busy),
    .op_o   (eng_op),
    .done_o (eng_done)
  );

  drng_hs_gen #(
    .N_WORDS (N_WORDS),
    .SEED    (SEED),
    .TAPS    (TAPS),
    .MIX     (MIX)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (eng_busy),
    .done_i  (eng_done),
    .op_i    (eng_op),
    .words_o (gen_words)
  );
endmodule

// File: rtl/drng_hs_checker.sv
module drng_hs_checker
  import drng_hs_pkg::*;
#(
  parameter int N_WORDS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [N_OPS-1:0]          req_vec,
  input logic [N_OPS-1:0]          ack_vec,
  input logic                      eng_busy,
  input logic [OP_W-1:0]           eng_op,
  input logic                      eng_done,
  input logic [N_WORDS*DATA_W-1:0] data_flat
);
  logic [N_OPS-1:0] clr_bits;
  logic             req_wr;

  assign clr_bits = (bus_we && bus_addr == ADDR_ACK) ? bus_wdata[N_OPS-1:0] : '0;
  assign req_wr   = bus_we && (bus_addr == ADDR_REQ);

  // R4: an acknowledge only falls under a clearing write
  a_r4_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ack_vec) & ~$past(clr_bits)) & ~ack_vec) == '0));

  // R5: a fresh acknowledge never coexists with its request
  a_r5_req_drops_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ack_vec & ~$past(ack_vec) & req_vec) == '0));

  // R3: unmasked request bits are untouched by a control write
  a_r3_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !eng_done) |=>
      (((req_vec ^ $past(req_vec)) & ~$past(bus_wdata[MASK_LSB +: N_OPS])) == '0));

  // R6: service always begins with the lowest pending request
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |->
      ((($past(req_vec) >> eng_op) & 5'd1) == 5'd1) &&
      (($past(req_vec) & ((5'd1 << eng_op) - 5'd1)) == '0));

  // R7: dropping the active request idles the engine next edge
  a_r7_abandon_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !req_vec[eng_op]) |=> !eng_busy);

  // R8: result words move only after a deterministic-draw completion
  a_r8_words_only_on_draw: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_flat == $past(data_flat)) ||
             ($past(eng_done) && $past(eng_op) == OP_SWDET));
endmodule

bind drng_handshake_regs drng_hs_checker #(.N_WORDS(N_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .req_vec   (req_vec),
  .ack_vec   (ack_vec),
  .eng_busy  (eng_busy),
  .eng_op    (eng_op),
  .eng_done  (eng_done),
  .data_flat (data_flat)
);

// File: tb/tb_drng_handshake_regs.sv
`timescale 1ns/1ps
module tb_drng_handshake_regs;
  localparam int          OPC  = 64;
  localparam logic [31:0] SEED = 32'hACE1_0001;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] MIX  = 32'h5A5A_C3C3;
  localparam logic [7:0]  A_REQ = 8'h10, A_ACK = 8'h14, A_WIN = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  always #2.5 clk = ~clk;

  drng_handshake_regs #(
    .OP_CYCLES (OPC), .N_WORDS (8), .SEED (SEED), .TAPS (TAPS), .MIX (MIX)
  ) dut (
    .clk (clk), .rst_n (rst_n), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  int n_vec = 0, n_bad = 0, n_cyc = 0;
  bit finished = 1'b0;

  // ---------------- reference model ----------------
  logic [4:0]  m_req, m_ack, n_req, n_ack;
  logic [31:0] m_lfsr, n_lfsr, s;
  logic [31:0] m_data [8];
  bit          m_busy, m_done;
  int          m_op, m_cnt;

  function automatic logic [31:0] stepf(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a == A_REQ) return {27'h0, m_req};
    if (a == A_ACK) return {27'h0, m_ack};
    if (a >= A_WIN && a < A_WIN + 8'd32 && a[1:0] == 2'b00) return m_data[(a - A_WIN) >> 2];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == A_REQ) return "R3";
    if (a == A_ACK) return "R4";
    if (a >= A_WIN && a < A_WIN + 8'd32) return "R8";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = '0; m_ack = '0; m_lfsr = SEED; m_busy = 0; m_op = 0; m_cnt = 0;
      for (int k = 0; k < 8; k++) m_data[k] = '0;
    end else begin
      m_done = m_busy && m_req[m_op] && (m_cnt == OPC - 1);
      n_req = m_req; n_ack = m_ack; n_lfsr = m_lfsr;
      if (bus_we && bus_addr == A_REQ)
        for (int i = 0; i < 5; i++) if (bus_wdata[16+i]) n_req[i] = bus_wdata[i];
      if (bus_we && bus_addr == A_ACK) n_ack = n_ack & ~bus_wdata[4:0];
      if (m_done) begin n_req[m_op] = 1'b0; n_ack[m_op] = 1'b1; end
      if (m_busy) begin
        n_lfsr = stepf(m_lfsr);
        if (m_done && m_op == 0) n_lfsr = SEED;
        if (m_done && m_op == 1) n_lfsr = stepf(m_lfsr) ^ MIX;
        if (m_done && m_op == 3) begin
          s = m_lfsr;
          for (int k = 0; k < 8; k++) begin s = stepf(s); m_data[k] = s; end
        end
      end
      if (!m_busy) begin
        if (m_req != 0) begin
          m_busy = 1;
          m_cnt = 0;
          for (int i = 4; i >= 0; i--) if (m_req[i]) m_op = i;
        end
      end else if (!m_req[m_op] || m_done) begin
        m_busy = 0; m_cnt = 0;
      end else begin
        m_cnt++;
      end
      m_req = n_req; m_ack = n_ack; m_lfsr = n_lfsr;
    end
  end

  // per-cycle comparison of the addressed register against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_vec++;
      if (bus_rdata !== mread(bus_addr)) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag_of(bus_addr),
                 bus_addr, bus_rdata, mread(bus_addr));
      end
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog R5 actual=%0d cycles expected=completion", n_cyc);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic wait_ack(input int idx, output int n);
    bus_we = 1'b0; bus_addr = A_ACK; n = 0;
    forever begin
      @(negedge clk);
      if (bus_rdata[idx] || n > 5000) break;
      @(posedge clk); #1;
      n++;
    end
    @(posedge clk); #1;
  endtask

  int n;
  int first [5];
  logic [31:0] saved, ref_word;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd("R1", A_REQ, 32'h0);
    expect_rd("R1", A_ACK, 32'h0);
    expect_rd("R1", A_WIN, 32'h0);
    expect_rd("R1", A_WIN + 8'd28, 32'h0);

    // R2 unmapped read, writes to the result window ignored
    expect_rd("R2", 8'h20, 32'h0);
    cyc(1, A_WIN, 32'hDEAD_BEEF);
    expect_rd("R2", A_WIN, 32'h0);

    // R3 masked write: only bit 2 is enabled
    cyc(1, A_REQ, 32'h0000_001F);
    expect_rd("R3", A_REQ, 32'h0);
    cyc(1, A_REQ, 32'h0004_001F);
    expect_rd("R3", A_REQ, 32'h4);
    // R5 latency: one cycle already spent above
    wait_ack(2, n);
    chk("R5", n, OPC);
    expect_rd("R5", A_REQ, 32'h0);

    // R4 write-0 keeps, write-1 clears
    cyc(1, A_ACK, 32'h0);
    expect_rd("R4", A_ACK, 32'h4);
    cyc(1, A_ACK, 32'h4);
    expect_rd("R4", A_ACK, 32'h0);

    // R8/R9 deterministic draw from the reset seed
    cyc(1, A_REQ, 32'h0008_0008);
    wait_ack(3, n);
    chk("R8", n, OPC + 1);
    bus_addr = A_WIN; @(negedge clk);
    chk("R8", (bus_rdata != 0), 1);
    @(posedge clk); #1;
    cyc(1, A_ACK, 32'h1F);

    // R9 instantiate reloads the seed; next draw gives step^OPC(SEED)
    cyc(1, A_REQ, 32'h0001_0001);
    wait_ack(0, n);
    cyc(1, A_ACK, 32'h1F);
    cyc(1, A_REQ, 32'h0008_0008);
    wait_ack(3, n);
    ref_word = SEED;
    repeat (OPC) ref_word = stepf(ref_word);
    expect_rd("R9", A_WIN, ref_word);
    ref_word = stepf(ref_word);
    expect_rd("R9", A_WIN + 8'd4, ref_word);
    cyc(1, A_ACK, 32'h1F);

    // R9 reseed then draw (checked by the model every cycle)
    cyc(1, A_REQ, 32'h0002_0002);
    wait_ack(1, n);
    cyc(1, A_REQ, 32'h0008_0008);
    wait_ack(3, n);
    expect_rd("R9", A_WIN + 8'd28, mread(A_WIN + 8'd28));
    cyc(1, A_ACK, 32'h1F);

    // R6 all five together: ascending order and spacing
    for (int i = 0; i < 5; i++) first[i] = -1;
    cyc(1, A_REQ, 32'h001F_001F);
    bus_addr = A_ACK;
    for (int t = 0; t < 6 * (OPC + 1) && first[4] < 0; t++) begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) if (bus_rdata[i] && first[i] < 0) first[i] = t;
      @(posedge clk); #1;
    end
    for (int i = 0; i < 5; i++) chk("R6", first[i], (i + 1) * (OPC + 1));
    cyc(1, A_ACK, 32'h1F);

    // R7 cancel an in-flight draw with an all-zero full-mask write
    bus_addr = A_WIN; @(negedge clk); saved = bus_rdata; @(posedge clk); #1;
    cyc(1, A_REQ, 32'h0008_0008);
    repeat (10) cyc(0, A_ACK, 32'h0);
    cyc(1, A_REQ, 32'hFFFF_0000);
    repeat (OPC + 5) cyc(0, A_ACK, 32'h0);
    expect_rd("R7", A_ACK, 32'h0);
    expect_rd("R7", A_REQ, 32'h0);
    expect_rd("R7", A_WIN, saved);

    // R4 completion beats a same-edge clearing write
    cyc(1, A_REQ, 32'h0004_0004);
    repeat (OPC) cyc(0, A_ACK, 32'h0);
    cyc(1, A_ACK, 32'h4);
    expect_rd("R4", A_ACK, 32'h4);
    cyc(1, A_ACK, 32'h1F);

    // R5 completion beats a same-edge request re-write
    cyc(1, A_REQ, 32'h0010_0010);
    repeat (OPC) cyc(0, A_ACK, 32'h0);
    cyc(1, A_REQ, 32'h0010_0010);
    expect_rd("R5", A_REQ, 32'h0);
    expect_rd("R5", A_ACK, 32'h10);

    repeat (4) cyc(0, A_REQ, 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule